// File: doc/BRIEF.md
# Peripheral Power Gate with Functional Enable

This block wraps one small peripheral and gives it two separate ways to save power. The light way is a run bit in the peripheral's own control register. Clearing it halts the peripheral's function, but its registers stay on the bus and can still be read and written. The heavy way is a module-off input, driven from a shared power-control register elsewhere on the chip. Setting it stops the peripheral's clock completely. While it is set, bus writes are lost and reads come back flagged as invalid with zero data.

The peripheral inside is a stand-in: an up/down counter with a programmable wrap limit and a sticky wrap flag. It is reached through a simple strobe-based register bus with a two-bit address. The clock gate captures its enable in a latch that is open only while the clock is low, so the gated clock never gets a short pulse. When the module-off input is cleared, the first restored clock edge resets every peripheral register. Software therefore always finds the peripheral in a known state after power-up.

Top module: `periph_pwr_gate`

## Requirements
- R1: With the run bit (CTRL bit 0, address 0) clear and the module on, the count does not change. COUNT (address 1) and LIMIT (address 2) can still be written and read back.
- R2: With run set and the direction bit (CTRL bit 1) clear, the count rises by one per clock. Once it has reached LIMIT, the next step goes to 0 and sets the wrap flag (STAT bit 0, address 3).
- R3: With run and the direction bit both set, the count falls by one per clock. A step taken from 0 reloads LIMIT and sets the wrap flag.
- R4: A write to COUNT loads the written value and takes priority over a count step in the same cycle. A STAT write with bit 0 set clears the wrap flag, but a wrap in the same cycle keeps the flag set. A STAT write with bit 0 clear leaves the flag unchanged.
- R5: While mod_off is high, gclk_o stays low and no peripheral register changes, whatever is written on the bus.
- R6: A read strobe issued while mod_off is high returns rd_valid low and rd_data zero on the following cycle.
- R7: A read strobe returns rd_valid high and the addressed register one cycle later. Unused upper bits of CTRL and STAT read as zero.
- R8: The first clock edge after mod_off falls resets all registers (CTRL 0, COUNT 0, LIMIT all ones, wrap flag 0). A read strobed in that cycle returns invalid. The same reset values are present after the synchronous reset.
- R9: fn_active is high exactly when the run bit is set and the peripheral clock is live.
- R10: A change of mod_off while clk is high does not change gclk_o until the next rising edge of clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 CTRL, 1 COUNT, 2 LIMIT, 3 STAT |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| mod_off | input | 1 | Module-off request; high stops the peripheral clock |
| gclk_o | output | 1 | Gated peripheral clock |
| fn_active | output | 1 | Peripheral function running |
| rd_data | output | DATA_W | Registered read data, zero when invalid |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |

## Verification
Several properties are checked on every cycle. While the module is off, none of the registers changes. While it is on with run clear, the count holds. The cycle after a restore edge shows reset values. A read can be valid only if it was strobed while the module was on, and invalid reads carry zero data. Each count step, up or down and away from the wrap points, moves the count by exactly one.

Other behaviour shows only in the bench scenarios. These cover the wrap arithmetic across sweeps of limit, start value and step count in both directions, and the write-over-count priority. They also cover the set-over-clear rule for the wrap flag, the invalid read in the restore cycle, and the gated clock holding steady when mod_off moves during the high phase.

// File: rtl/pgate_pkg.sv
package pgate_pkg;

    localparam int unsigned REG_AW        = 2;
    localparam int unsigned CTRL_RUN_BIT  = 0;
    localparam int unsigned CTRL_DIR_BIT  = 1;
    localparam int unsigned STAT_WRAP_BIT = 0;

    typedef enum logic [REG_AW-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_LIMIT = 2'd2,
        SEL_STAT  = 2'd3
    } reg_sel_e;

    // packed so that dir_down sits at bit 1 and run at bit 0
    typedef struct packed {
        logic dir_down;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic     valid;
        reg_sel_e sel;
    } bus_op_t;

    function automatic ctrl_t ctrl_decode(input logic [1:0] bits);
        ctrl_t c;
        c.run      = bits[CTRL_RUN_BIT];
        c.dir_down = bits[CTRL_DIR_BIT];
        return c;
    endfunction

    function automatic logic [1:0] ctrl_encode(input ctrl_t c);
        logic [1:0] b;
        b[CTRL_RUN_BIT] = c.run;
        b[CTRL_DIR_BIT] = c.dir_down;
        return b;
    endfunction

endpackage

// File: rtl/pgate_clk_gate.sv
module pgate_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // enable only follows its input during the low phase of clk
    always_latch begin
        if (!clk) en_lat <= en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/pgate_counter_core.sv
module pgate_counter_core
    import pgate_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              gclk,
    input  logic              rst_core,
    input  bus_op_t           wr_op,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic [DATA_W-1:0] limit_q,
    output logic              wrap_q
);
    logic              wr_ctrl, wr_count, wr_limit, wr_stat;
    logic              at_top, at_bottom, step_wrap;
    logic [DATA_W-1:0] cnt_step;

    always_comb begin
        wr_ctrl  = wr_op.valid && (wr_op.sel == SEL_CTRL);
        wr_count = wr_op.valid && (wr_op.sel == SEL_COUNT);
        wr_limit = wr_op.valid && (wr_op.sel == SEL_LIMIT);
        wr_stat  = wr_op.valid && (wr_op.sel == SEL_STAT);
    end

    always_comb begin
        at_top    = (cnt_q >= limit_q);
        at_bottom = (cnt_q == '0);
        if (ctrl_q.dir_down) begin
            step_wrap = at_bottom;
            cnt_step  = at_bottom ? limit_q : cnt_q - 1'b1;
        end else begin
            step_wrap = at_top;
            cnt_step  = at_top ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge gclk) begin
        if (rst_core) begin
            ctrl_q  <= '0;
            cnt_q   <= '0;
            limit_q <= '1;
            wrap_q  <= 1'b0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= ctrl_decode(wr_data[1:0]);
            if (wr_limit) limit_q <= wr_data;
            if (wr_count)         cnt_q <= wr_data;
            else if (ctrl_q.run)  cnt_q <= cnt_step;
            if (ctrl_q.run && !wr_count && step_wrap)
                wrap_q <= 1'b1;
            else if (wr_stat && wr_data[STAT_WRAP_BIT])
                wrap_q <= 1'b0;
        end
    end

    // R2
    up_step_chk: assert property (@(posedge gclk) disable iff (rst_core)
        (ctrl_q.run && !ctrl_q.dir_down && !wr_count && (cnt_q < limit_q))
        |=> (cnt_q == DATA_W'($past(cnt_q) + 1'b1)));

    // R3
    down_step_chk: assert property (@(posedge gclk) disable iff (rst_core)
        (ctrl_q.run && ctrl_q.dir_down && !wr_count && (cnt_q != '0))
        |=> (cnt_q == DATA_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/pgate_read_port.sv
module pgate_read_port
    import pgate_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           rd_op,
    input  logic              blocked,
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] limit,
    input  logic              wrap,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [DATA_W-1:0] word;
    logic              take;

    always_comb begin
        word = '0;
        unique case (rd_op.sel)
            SEL_CTRL:  word[1:0]           = ctrl_encode(ctrl);
            SEL_COUNT: word                = cnt;
            SEL_LIMIT: word                = limit;
            SEL_STAT:  word[STAT_WRAP_BIT] = wrap;
            default:   word                = '0;
        endcase
        take = rd_op.valid && !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take;
            rd_data  <= take ? word : '0;
        end
    end

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

    // R7
    valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_op.valid));
endmodule

// File: rtl/periph_pwr_gate.sv
module periph_pwr_gate
    import pgate_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic              mod_off,
    output logic              gclk_o,
    output logic              fn_active,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              off_q;
    logic              rst_core;
    logic              blocked;
    logic              gate_en;
    bus_op_t           wr_op, rd_op;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] cnt, limit;
    logic              wrap;

    // off_q marks that the last edge had the clock removed; the first live
    // edge afterwards therefore resets the peripheral
    always_ff @(posedge clk) begin
        if (rst) off_q <= 1'b1;
        else     off_q <= mod_off;
    end

    always_comb begin
        gate_en     = !mod_off;
        rst_core    = rst || off_q;
        blocked     = mod_off || off_q;
        wr_op.valid = bus_we;
        wr_op.sel   = reg_sel_e'(bus_addr);
        rd_op.valid = bus_re;
        rd_op.sel   = reg_sel_e'(bus_addr);
        fn_active   = ctrl.run && !blocked;
    end

    pgate_clk_gate u_gate (
        .clk  (clk),
        .en   (gate_en),
        .gclk (gclk_o)
    );

    pgate_counter_core #(.DATA_W(DATA_W)) u_core (
        .gclk     (gclk_o),
        .rst_core (rst_core),
        .wr_op    (wr_op),
        .wr_data  (bus_wdata),
        .ctrl_q   (ctrl),
        .cnt_q    (cnt),
        .limit_q  (limit),
        .wrap_q   (wrap)
    );

    pgate_read_port #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_op    (rd_op),
        .blocked  (blocked),
        .ctrl     (ctrl),
        .cnt      (cnt),
        .limit    (limit),
        .wrap     (wrap),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // R5
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        mod_off |=> ($stable(cnt) && $stable(limit) && $stable(ctrl) && $stable(wrap)));

    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!blocked && !ctrl.run && !bus_we) |=> $stable(cnt));

    // R8
    restore_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (off_q && !mod_off) |=> (cnt == '0 && limit == '1 && !wrap && ctrl == '0));

    // R6
    no_valid_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mod_off));
endmodule

// File: tb/sim_periph_pwr_gate.sv
module sim_periph_pwr_gate;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic          mod_off = 1'b0;
    logic          gclk_o, fn_active, rd_valid;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    periph_pwr_gate #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .mod_off(mod_off), .gclk_o(gclk_o),
        .fn_active(fn_active), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [DW-1:0] d, output logic v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk); #2;
        d = rd_data; v = rd_valid;
        bus_re = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        logic [DW-1:0] d;
        logic v;
        bus_rd(a, d, v);
        check({tag, " valid"}, int'(v), 1);
        check({tag, " data"}, int'(d), exp);
    endtask

    // counts k steps from s with limit L in the chosen direction
    task automatic sweep(input int L, input int s, input int k, input bit dn);
        int m, e, w;
        bus_wr(2'd2, DW'(L));
        bus_wr(2'd1, DW'(s));
        bus_wr(2'd3, 8'd1);
        bus_wr(2'd0, dn ? 8'd3 : 8'd1);
        repeat (k - 1) @(negedge clk);
        bus_wr(2'd0, 8'd0);
        m = L + 1;
        if (!dn) begin
            e = (s + k) % m;
            w = ((s + k) > L) ? 1 : 0;
            rd_chk("R2 count", 2'd1, e);
            rd_chk("R2 wrap", 2'd3, w);
        end else begin
            e = (((s - k) % m) + m) % m;
            w = (k > s) ? 1 : 0;
            rd_chk("R3 count", 2'd1, e);
            rd_chk("R3 wrap", 2'd3, w);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic v;

        repeat (3) @(negedge clk);
        check("R8 reset rd_valid", int'(rd_valid), 0);
        check("R9 reset fn_active", int'(fn_active), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk("R8 reset CTRL", 2'd0, 0);
        rd_chk("R8 reset COUNT", 2'd1, 0);
        rd_chk("R8 reset LIMIT", 2'd2, 255);
        rd_chk("R8 reset STAT", 2'd3, 0);

        // R1: registers usable with run clear, count holds
        bus_wr(2'd2, 8'd20);
        bus_wr(2'd1, 8'd5);
        repeat (10) @(negedge clk);
        rd_chk("R1 count held", 2'd1, 5);
        rd_chk("R1 limit rw", 2'd2, 20);

        // R7: unused CTRL bits read zero
        bus_wr(2'd0, 8'hFF);
        rd_chk("R7 ctrl bits", 2'd0, 3);
        bus_wr(2'd0, 8'h00);

        // R4: load beats count step
        bus_wr(2'd2, 8'd255);
        bus_wr(2'd1, 8'd0);
        bus_wr(2'd0, 8'd1);
        bus_wr(2'd1, 8'd42);
        bus_wr(2'd0, 8'd0);
        rd_chk("R4 load priority", 2'd1, 43);

        // R4: wrap set beats clear in the same cycle
        bus_wr(2'd2, 8'd3);
        bus_wr(2'd1, 8'd3);
        bus_wr(2'd3, 8'd1);
        bus_wr(2'd0, 8'd1);
        bus_wr(2'd3, 8'd1);
        bus_wr(2'd0, 8'd0);
        rd_chk("R4 set wins", 2'd3, 1);
        rd_chk("R4 count after wrap", 2'd1, 1);
        bus_wr(2'd3, 8'hFE);
        rd_chk("R4 bit0 zero keeps", 2'd3, 1);
        bus_wr(2'd3, 8'h01);
        rd_chk("R4 clear", 2'd3, 0);

        // R2 / R3 sweeps over small limits
        for (int L = 3; L <= 7; L += 4)
            for (int s = 0; s <= L; s++)
                for (int k = 1; k <= 2 * L + 2; k++) begin
                    sweep(L, s, k, 1'b0);
                    sweep(L, s, k, 1'b1);
                end
        sweep(255, 250, 10, 1'b0);
        sweep(255, 3, 5, 1'b1);

        // R9: fn_active follows run and clock
        bus_wr(2'd2, 8'd9);
        bus_wr(2'd1, 8'd4);
        bus_wr(2'd0, 8'd3);
        check("R9 active on", int'(fn_active), 1);

        // R10: disable during high phase keeps pulse
        @(posedge clk); #2;
        mod_off = 1'b1;
        #1 check("R10 pulse kept", int'(gclk_o), 1);
        check("R9 active off", int'(fn_active), 0);
        @(posedge clk); #1;
        check("R5 gclk off", int'(gclk_o), 0);

        // R5 / R6: writes lost, reads invalid
        for (int i = 0; i < 3; i++) begin
            bus_wr(2'd1, 8'd77);
            check("R5 gclk low", int'(gclk_o), 0);
        end
        bus_rd(2'd1, d, v);
        check("R6 valid off", int'(v), 0);
        check("R6 data zero", int'(d), 0);

        // R10: enable during high phase waits for next edge
        @(posedge clk); #2;
        mod_off = 1'b0;
        #1 check("R10 no early pulse", int'(gclk_o), 0);
        @(posedge clk); #1;
        check("R10 gclk back", int'(gclk_o), 1);
        repeat (2) @(negedge clk);
        rd_chk("R8 restore CTRL", 2'd0, 0);
        rd_chk("R8 restore COUNT", 2'd1, 0);
        rd_chk("R8 restore LIMIT", 2'd2, 255);
        rd_chk("R8 restore STAT", 2'd3, 0);
        check("R9 active after restore", int'(fn_active), 0);

        // R8: read in the restore cycle is invalid
        @(negedge clk);
        mod_off = 1'b1;
        repeat (2) @(negedge clk);
        mod_off = 1'b0;
        bus_addr = 2'd2; bus_re = 1'b1;
        @(posedge clk); #2;
        check("R8 restore read invalid", int'(rd_valid), 0);
        bus_re = 1'b0;
        rd_chk("R8 next read valid", 2'd2, 255);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule